// File: doc/BRIEF.md
# Peripheral interrupt and wake controller

This block gathers interrupt requests from a small set of peripherals and from two input ports, and turns them into one interrupt line for a CPU. The peripheral requests are single-cycle pulses: timer, half-second tick, UART transmit complete and UART receive ready. Each pulse sets a sticky flag. Software clears a flag by writing a one to its bit.

The first input port is a 4-bit key port. It raises a flag for as long as any enabled pin is held low. The second is an 8-bit general port with per-pin direction bits. Each of its input pins has a sticky flag that is set on a rising or a falling edge, chosen per pin. A summary bit in the main flag register reports whether any of these pin flags is set. Both ports pass through a two-flop synchronizer.

The block also drives a wake request. In sleep mode only the two ports can wake the CPU. In standby mode the half-second tick and an external non-maskable pulse can wake it as well.

Top module: `irq_wake_ctrl`

Register map (3-bit address, 8-bit data, writes take effect on the clock edge while `bus_we` is high, reads are combinational):
- address 0: flag register. Bit 0 timer, bit 1 key port, bit 2 half-second tick, bit 3 transmit complete, bit 4 receive ready, bit 5 port summary. Bits 7..6 read 0.
- address 1: per-pin port flags.
- address 2: per-pin port enable, active low.
- address 3: per-pin port polarity, 1 for rising and 0 for falling.
- address 4: key enable in bits 3..0, active low. Bits 7..4 read 0.

## Requirements
- R1: After reset the registers read as follows: address 0 reads 0x00, address 1 reads 0x00, address 2 reads 0xFF, address 3 reads 0x00 and address 4 reads 0x0F. `irq` and `wake` are 0.
- R2: A one-cycle pulse on `tmr_pulse`, `half_pulse`, `tx_pulse` or `rx_pulse` sets bit 0, 2, 3 or 4 of address 0 respectively, and the bit is readable after that clock edge.
- R3: Writing address 0 clears each of bits 0..4 whose data bit is 1. A data bit of 0 leaves its flag unchanged. When a set and a clear of the same flag fall in one cycle, the flag is set.
- R4: Bit 5 of address 0 reads as the OR of the port flags at address 1. Writing address 0 does not change it, whatever the data.
- R5: An edge on a port input pin sets that pin's flag three clock edges after the pin changes. With polarity bit 1 only a 0-to-1 edge sets it; with polarity bit 0 only a 1-to-0 edge sets it.
- R6: A port flag stays set after its pin returns to the earlier level. Writing a 1 to its bit at address 1 clears it; writing a 0 leaves it set.
- R7: A port pin raises its flag only when its enable bit at address 2 is 0 and its `gp_dir` bit is 0. A `gp_dir` bit of 1 marks the pin as an output, and an output pin raises no flag whatever its enable bit holds.
- R8: While a key pin whose enable bit at address 4 is 0 is held low, bit 1 of address 0 is set three clock edges after the pin went low. The bit is set again on every cycle the pin stays low, even after software clears it. A low level on a disabled key pin sets nothing.
- R9: `irq` is 1 when any of bits 1..5 of address 0 is set, or when bit 0 is set and `tmr_irq_en` is 1.
- R10: While `sleep` is 1, `wake` is 1 exactly when bit 1 or bit 5 of address 0 is set.
- R11: While `standby` is 1 and `sleep` is 0, `wake` is 1 exactly when bit 1, bit 2 or bit 5 of address 0 is set, or `nmi_pulse` is 1. With neither mode active, `wake` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| key_in | input | 4 | Key port pins |
| gp_in | input | 8 | General port pin levels |
| gp_dir | input | 8 | Per-pin direction, 1 = output |
| tmr_pulse | input | 1 | Timer request pulse |
| tmr_irq_en | input | 1 | Timer interrupt enable |
| half_pulse | input | 1 | Half-second tick pulse |
| tx_pulse | input | 1 | Transmit complete pulse |
| rx_pulse | input | 1 | Receive ready pulse |
| nmi_pulse | input | 1 | Non-maskable source, used only for wake |
| standby | input | 1 | Standby mode indication |
| sleep | input | 1 | Sleep mode indication |
| irq | output | 1 | Interrupt request to the CPU |
| wake | output | 1 | Wake request |

## Verification
The general port is driven by a table of level transitions. The table crosses rising and falling edges with each polarity setting, with partial enable masks and with partial output-direction masks, so an inverted polarity, a dropped enable or an ignored direction bit each give a distinct wrong flag pattern. Directed tests then cover the other behaviours:
- the latency of the synchronizer, cycle by cycle;
- a set and a clear of one flag in the same cycle;
- writes of 0 and of 1 to the flags;
- the summary bit withstanding a write of ones to address 0;
- the key level re-asserting its flag while held;
- every wake combination in sleep, standby and run mode, including a source that wakes from standby but not from sleep.

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl #(
  parameter int DW = 8,
  parameter int KW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [KW-1:0] key_in,
  input  logic [DW-1:0] gp_in,
  input  logic [DW-1:0] gp_dir,
  input  logic          tmr_pulse,
  input  logic          tmr_irq_en,
  input  logic          half_pulse,
  input  logic          tx_pulse,
  input  logic          rx_pulse,
  input  logic          nmi_pulse,
  input  logic          standby,
  input  logic          sleep,
  output logic          irq,
  output logic          wake
);
  localparam int NF = 5;

  logic [KW-1:0] k_s1, k_s2, ken_n_q;
  logic [DW-1:0] p_s1, p_s2, p_prev;
  logic [DW-1:0] pflag_q, pen_n_q, pol_q;
  logic [NF-1:0] flag_q;

  wire wr_flag = bus_we && bus_addr == 3'd0;
  wire wr_pfl  = bus_we && bus_addr == 3'd1;
  wire wr_pen  = bus_we && bus_addr == 3'd2;
  wire wr_pol  = bus_we && bus_addr == 3'd3;
  wire wr_ken  = bus_we && bus_addr == 3'd4;

  wire          key_hit = |(~k_s2 & ~ken_n_q);
  wire [DW-1:0] p_edge  = (pol_q & p_s2 & ~p_prev) | (~pol_q & ~p_s2 & p_prev);
  wire [DW-1:0] p_hit   = p_edge & ~pen_n_q & ~gp_dir;
  wire [NF-1:0] f_set   = {rx_pulse, tx_pulse, half_pulse, key_hit, tmr_pulse};
  wire [NF-1:0] f_clr   = wr_flag ? bus_wdata[NF-1:0] : '0;
  wire [DW-1:0] p_clr   = wr_pfl ? bus_wdata : '0;
  wire          p_any   = |pflag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_s1    <= '1;
      k_s2    <= '1;
      p_s1    <= '0;
      p_s2    <= '0;
      p_prev  <= '0;
      flag_q  <= '0;
      pflag_q <= '0;
      pen_n_q <= '1;
      pol_q   <= '0;
      ken_n_q <= '1;
    end else begin
      k_s1    <= key_in;
      k_s2    <= k_s1;
      p_s1    <= gp_in;
      p_s2    <= p_s1;
      p_prev  <= p_s2;
      flag_q  <= (flag_q & ~f_clr) | f_set;
      pflag_q <= (pflag_q & ~p_clr) | p_hit;
      if (wr_pen) pen_n_q <= bus_wdata;
      if (wr_pol) pol_q   <= bus_wdata;
      if (wr_ken) ken_n_q <= bus_wdata[KW-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      3'd0:    bus_rdata[NF:0] = {p_any, flag_q};
      3'd1:    bus_rdata = pflag_q;
      3'd2:    bus_rdata = pen_n_q;
      3'd3:    bus_rdata = pol_q;
      3'd4:    bus_rdata[KW-1:0] = ken_n_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq  = (flag_q[0] & tmr_irq_en) | (|flag_q[NF-1:1]) | p_any;
  assign wake = sleep   ? (flag_q[1] | p_any) :
                standby ? (flag_q[1] | flag_q[2] | p_any | nmi_pulse) : 1'b0;
endmodule

// File: rtl/irq_wake_chk.sv
module irq_wake_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [2:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] gp_dir,
  input logic [4:0]    flag_q,
  input logic [DW-1:0] pflag_q,
  input logic          tmr_pulse,
  input logic          nmi_pulse,
  input logic          standby,
  input logic          sleep,
  input logic          irq,
  input logic          wake
);
  p_timer_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_pulse |=> flag_q[0]);

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0 && bus_wdata[0] && !tmr_pulse) |=> !flag_q[0]);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == 3'd1) |=> ((pflag_q & $past(pflag_q)) == $past(pflag_q)));

  p_dir_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pflag_q & ~$past(pflag_q) & $past(gp_dir)) == '0));

  p_irq_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|pflag_q) |-> irq);

  p_sleep_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !flag_q[1] && pflag_q == '0) |-> !wake);

  p_standby_nmi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !sleep && nmi_pulse) |-> wake);
endmodule

bind irq_wake_ctrl irq_wake_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .gp_dir(gp_dir), .flag_q(flag_q), .pflag_q(pflag_q),
  .tmr_pulse(tmr_pulse), .nmi_pulse(nmi_pulse), .standby(standby),
  .sleep(sleep), .irq(irq), .wake(wake)
);

// File: tb/irq_wake_ctrl_tb_top.sv
module irq_wake_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [3:0] key_in = 4'hF;
  logic [7:0] gp_in = 0, gp_dir = 0;
  logic tmr_pulse = 0, tmr_irq_en = 0, half_pulse = 0, tx_pulse = 0, rx_pulse = 0;
  logic nmi_pulse = 0, standby = 0, sleep = 0, irq, wake;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  irq_wake_ctrl dut_i (.*);

  // {start, final, polarity, enable_n, dir, expected port flags}
  localparam logic [47:0] VEC [8] = '{
    {8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF},
    {8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF},
    {8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00},
    {8'h00, 8'hFF, 8'hFF, 8'h0F, 8'h00, 8'hF0},
    {8'h00, 8'hFF, 8'hFF, 8'h00, 8'h33, 8'hCC},
    {8'h00, 8'hA5, 8'hFF, 8'h00, 8'h00, 8'hA5},
    {8'h5A, 8'h00, 8'h0F, 8'h00, 8'h00, 8'h50}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    idle(2); rst_n = 1; idle(1);
    rd(0, d); chk(d, 8'h00, "R1 flags");
    rd(1, d); chk(d, 8'h00, "R1 port flags");
    rd(2, d); chk(d, 8'hFF, "R1 enable");
    rd(3, d); chk(d, 8'h00, "R1 polarity");
    rd(4, d); chk(d, 8'h0F, "R1 key enable");
    chk({6'b0, irq, wake}, 8'h00, "R1 irq/wake");

    foreach (VEC[i]) begin
      gp_dir = VEC[i][15:8];
      wr(3, VEC[i][31:24]);
      wr(2, VEC[i][23:16]);
      gp_in = VEC[i][47:40];
      idle(5);
      wr(1, 8'hFF);
      idle(1);
      gp_in = VEC[i][39:32];
      idle(5);
      rd(1, d);
      chk(d, VEC[i][7:0], $sformatf("R5 R7 vector %0d", i));
    end
    gp_dir = 0; gp_in = 0; wr(3, 8'h00); wr(2, 8'hFF); idle(5); wr(1, 8'hFF);

    wr(2, 8'hFE); wr(3, 8'h01);
    @(negedge clk); gp_in = 8'h01;
    idle(2); rd(1, d); chk(d, 8'h00, "R5 latency edge 2");
    idle(1); rd(1, d); chk(d, 8'h01, "R5 latency edge 3");
    gp_in = 0; idle(5);
    rd(1, d); chk(d, 8'h01, "R6 sticky after return");
    rd(0, d); chk(d, 8'h20, "R4 summary bit");
    chk({7'b0, irq}, 8'h01, "R9 irq from port");
    wr(0, 8'hFF); rd(0, d); chk(d, 8'h20, "R4 summary survives flag write");
    wr(1, 8'h00); rd(1, d); chk(d, 8'h01, "R6 write zero keeps");
    wr(1, 8'h01); rd(1, d); chk(d, 8'h00, "R6 write one clears");
    rd(0, d); chk(d, 8'h00, "R4 summary cleared");
    wr(2, 8'hFF);

    pulse(tmr_pulse);
    rd(0, d); chk(d, 8'h01, "R2 timer flag");
    chk({7'b0, irq}, 8'h00, "R9 timer gated off");
    tmr_irq_en = 1; #1 chk({7'b0, irq}, 8'h01, "R9 timer gated on");
    tmr_irq_en = 0;
    pulse(half_pulse); pulse(tx_pulse); pulse(rx_pulse);
    rd(0, d); chk(d, 8'h1D, "R2 all pulse flags");
    wr(0, 8'h00); rd(0, d); chk(d, 8'h1D, "R3 write zero");
    wr(0, 8'h05); rd(0, d); chk(d, 8'h18, "R3 partial clear");
    @(negedge clk); tx_pulse = 1; bus_we = 1; bus_addr = 0; bus_wdata = 8'h18;
    @(negedge clk); tx_pulse = 0; bus_we = 0;
    rd(0, d); chk(d, 8'h08, "R3 set wins over clear");
    wr(0, 8'hFF); rd(0, d); chk(d, 8'h00, "R3 clear all");
    chk({7'b0, irq}, 8'h00, "R9 idle irq");

    @(negedge clk); key_in = 4'hE; idle(5);
    rd(0, d); chk(d, 8'h00, "R8 disabled key ignored");
    wr(4, 8'h0E); idle(1);
    rd(0, d); chk(d, 8'h02, "R8 enabled key low");
    wr(0, 8'h02); rd(0, d); chk(d, 8'h02, "R8 level re-asserts");
    key_in = 4'hF; idle(4); wr(0, 8'h02); rd(0, d); chk(d, 8'h00, "R8 released");

    pulse(half_pulse);
    sleep = 1; #1 chk({7'b0, wake}, 8'h00, "R10 half tick no sleep wake");
    sleep = 0; standby = 1; #1 chk({7'b0, wake}, 8'h01, "R11 half tick standby wake");
    wr(0, 8'h04); pulse(rx_pulse);
    #1 chk({7'b0, wake}, 8'h00, "R11 rx no standby wake");
    nmi_pulse = 1; #1 chk({7'b0, wake}, 8'h01, "R11 nmi standby wake");
    sleep = 1; #1 chk({7'b0, wake}, 8'h00, "R10 nmi no sleep wake");
    nmi_pulse = 0; wr(0, 8'hFF);
    @(negedge clk); key_in = 4'hE; idle(4);
    chk({7'b0, wake}, 8'h01, "R10 key sleep wake");
    key_in = 4'hF; idle(4); wr(0, 8'h02);
    wr(2, 8'hFE); wr(3, 8'h01); @(negedge clk); gp_in = 8'h01; idle(4);
    chk({7'b0, wake}, 8'h01, "R10 port sleep wake");
    sleep = 0; standby = 0; #1 chk({7'b0, wake}, 8'h00, "R11 run mode no wake");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule